// File: doc/BRIEF.md
# Two-Operand and Single-Operand ALU with Status Flags

This block is the execute stage of a small 16-bit processor. Each cycle it may accept one operation, given as the raw opcode fields of the instruction. These are the major field (instruction bits 15:12) for the two-operand group and the minor field (instruction bits 9:7) for the single-operand group, a group select and a byte/word select. With them come the source and destination operand values and the current status word. Operand fetch happens elsewhere. The block returns the value for the destination, a destination write strobe, and the next carry, zero, negative and overflow flags with a flag write strobe.

All outputs are registered, so a result appears one clock after the operation is accepted. Operations that do not change the status bits return the incoming flags unchanged on the flag outputs. The caller can therefore always take the flag outputs as the next status. Decimal add, the stack-related single-operand codes and any code outside the supported set complete as no-ops: nothing is written and no flag is updated.

Top module: `alu_core`

## Requirements
- R1: While `rst_n` is low on a clock edge, `out_valid`, `result_we`, `flags_we`, `result` and all four flag outputs become 0.
- R2: Outputs for an operation accepted with `in_valid` high appear after exactly one rising edge. After an edge where `in_valid` was low, `out_valid`, `result_we` and `flags_we` are 0.
- R3: ADD (major 5) gives dst+src. ADDC (major 6) gives dst+src+C. C is the carry out of the top result bit, Z is set for a zero result, and N is the top result bit.
- R4: SUB (major 8) and CMP (major 9) compute dst+~src+1. SUBC (major 7) computes dst+~src+C. CMP updates the flags but never writes the destination.
- R5: For the adder operations, V is set when dst and the adder's second input (src, or ~src when subtracting) share a sign and the result's sign differs from it.
- R6: MOV (major 4, result src), BIC (major 12, dst AND NOT src) and BIS (major 13, dst OR src) write the destination. They leave `flags_we` low and pass the incoming status bits through: C is bit 0, Z bit 1, N bit 2, V bit 8.
- R7: BIT (major 11, no write), AND (major 15) and XOR (major 14) form N from the result's top bit, Z for a zero result, and C as the inverse of Z. V is 0, except that XOR sets V when both operands are negative.
- R8: With `byte_mode` high, only the low 8 bits take part: the result's upper byte is 0, carry comes out of bit 7 and the sign is bit 7 (SWPB and SXT excepted, see R10).
- R9: With `is_single` high, the operand is `src_val`. Minor 0 (RRC) shifts right with the old C entering the top bit. Minor 2 (RRA) shifts right keeping the top bit. For both, C takes the shifted-out bit 0, V is 0, and N and Z follow the result.
- R10: Minor 1 (SWPB) swaps the two bytes of the full word and updates no flag. Minor 3 (SXT) copies bit 7 into bits 15:8, with N taken from bit 15, C the inverse of Z and V 0. Both always work on the full word.
- R11: DADD (major 10), majors 0 to 3 in the two-operand group and minors 4 to 7 in the single-operand group write nothing and update no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| is_single | input | 1 | 1 selects the single-operand group, 0 the two-operand group |
| major_op | input | 4 | Two-operand opcode field |
| minor_op | input | 3 | Single-operand opcode field |
| byte_mode | input | 1 | 1 for byte width, 0 for word width |
| src_val | input | 16 | Source operand (the only operand for the single-operand group) |
| dst_val | input | 16 | Destination operand |
| status_in | input | 16 | Current status word (C bit 0, Z bit 1, N bit 2, V bit 8) |
| out_valid | output | 1 | Registered outputs belong to an accepted operation |
| result | output | 16 | Value for the destination |
| result_we | output | 1 | Destination write strobe |
| c_out | output | 1 | Next carry flag |
| z_out | output | 1 | Next zero flag |
| n_out | output | 1 | Next negative flag |
| v_out | output | 1 | Next overflow flag |
| flags_we | output | 1 | Status flag update strobe |

## Verification
Several properties are checked on every cycle. Idle cycles raise no strobe, and an accepted operation always shows up one edge later. CMP never writes, and byte results keep a clear upper byte. A written result with updated flags has Z matching it, and the logic group keeps C equal to the inverse of Z. Shifts clear V, and the flags pass through whenever no update is flagged. The actual sums, borrows, overflow cases, rotations through carry, byte swap and sign extension are shown only by the bench's scenarios, which compare every output against an independent model of each operation.

// File: rtl/alu_pkg.sv
// Shared types for the ALU: decoded operation, carry-in source and control bundle.
// Assumes the status word layout C=0, Z=1, N=2, V=8.
package alu_pkg;

    localparam int SR_C_BIT = 0;
    localparam int SR_Z_BIT = 1;
    localparam int SR_N_BIT = 2;
    localparam int SR_V_BIT = 8;

    typedef enum logic [3:0] {
        OP_NONE, OP_MOV, OP_ADD, OP_ADDC, OP_SUBC, OP_SUB, OP_CMP, OP_BIT,
        OP_BIC,  OP_BIS, OP_XOR, OP_AND,  OP_RRC,  OP_SWPB, OP_RRA, OP_SXT
    } op_e;

    typedef enum logic [1:0] {
        CIN_ZERO,
        CIN_ONE,
        CIN_FLAG
    } cin_e;

    typedef struct packed {
        op_e  op;
        logic wr;         // destination is written
        logic fl;         // flags are updated
        logic inv;        // adder takes the inverted source
        cin_e cin;        // adder carry-in source
        logic word_only;  // byte select is ignored
    } ctrl_t;

endpackage

// File: rtl/alu_decode.sv
// Opcode decoder: turns the group select and the major/minor fields into a control bundle.
// Assumes unsupported codes (decimal add, stack codes, jump space) become OP_NONE.
module alu_decode
    import alu_pkg::*;
(
    input  logic       is_single,
    input  logic [3:0] major_op,
    input  logic [2:0] minor_op,
    output ctrl_t      ctrl
);

    // Map the fields onto an operation and its write, flag and adder settings.
    always_comb begin
        ctrl = '{op: OP_NONE, wr: 1'b0, fl: 1'b0, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b0};
        if (is_single) begin
            unique case (minor_op)
                3'd0: ctrl = '{op: OP_RRC,  wr: 1'b1, fl: 1'b1, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b0};
                3'd1: ctrl = '{op: OP_SWPB, wr: 1'b1, fl: 1'b0, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b1};
                3'd2: ctrl = '{op: OP_RRA,  wr: 1'b1, fl: 1'b1, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b0};
                3'd3: ctrl = '{op: OP_SXT,  wr: 1'b1, fl: 1'b1, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b1};
                default: ;
            endcase
        end else begin
            unique case (major_op)
                4'd4:  ctrl = '{op: OP_MOV,  wr: 1'b1, fl: 1'b0, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b0};
                4'd5:  ctrl = '{op: OP_ADD,  wr: 1'b1, fl: 1'b1, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b0};
                4'd6:  ctrl = '{op: OP_ADDC, wr: 1'b1, fl: 1'b1, inv: 1'b0, cin: CIN_FLAG, word_only: 1'b0};
                4'd7:  ctrl = '{op: OP_SUBC, wr: 1'b1, fl: 1'b1, inv: 1'b1, cin: CIN_FLAG, word_only: 1'b0};
                4'd8:  ctrl = '{op: OP_SUB,  wr: 1'b1, fl: 1'b1, inv: 1'b1, cin: CIN_ONE,  word_only: 1'b0};
                4'd9:  ctrl = '{op: OP_CMP,  wr: 1'b0, fl: 1'b1, inv: 1'b1, cin: CIN_ONE,  word_only: 1'b0};
                4'd11: ctrl = '{op: OP_BIT,  wr: 1'b0, fl: 1'b1, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b0};
                4'd12: ctrl = '{op: OP_BIC,  wr: 1'b1, fl: 1'b0, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b0};
                4'd13: ctrl = '{op: OP_BIS,  wr: 1'b1, fl: 1'b0, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b0};
                4'd14: ctrl = '{op: OP_XOR,  wr: 1'b1, fl: 1'b1, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b0};
                4'd15: ctrl = '{op: OP_AND,  wr: 1'b1, fl: 1'b1, inv: 1'b0, cin: CIN_ZERO, word_only: 1'b0};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/alu_addsub.sv
// Adder for add/subtract: computes a + (b or ~b) + cin at full or half width.
// Assumes W is even; in half-width mode the upper half of the sum is zero.
module alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_i,
    input  logic         cin_i,
    input  logic         half_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);

    localparam int H = W / 2;

    logic [W-1:0] bop;
    logic [W:0]   wsum;
    logic [H:0]   hsum;

    // Second adder input and the two width variants of the sum.
    always_comb begin
        bop  = inv_i ? ~b_i : b_i;
        wsum = {1'b0, a_i} + {1'b0, bop} + {{W{1'b0}}, cin_i};
        hsum = {1'b0, a_i[H-1:0]} + {1'b0, bop[H-1:0]} + {{H{1'b0}}, cin_i};
    end

    // Pick the width and derive carry and signed overflow from it.
    always_comb begin
        if (half_i) begin
            sum_o  = {{(W-H){1'b0}}, hsum[H-1:0]};
            cout_o = hsum[H];
            ovf_o  = (a_i[H-1] == bop[H-1]) && (hsum[H-1] != a_i[H-1]);
        end else begin
            sum_o  = wsum[W-1:0];
            cout_o = wsum[W];
            ovf_o  = (a_i[W-1] == bop[W-1]) && (wsum[W-1] != a_i[W-1]);
        end
    end

endmodule

// File: rtl/alu_bitops.sv
// Non-adder datapath: move, bitwise logic, right shifts, byte swap and sign extension.
// Assumes half_i is already cleared for full-word-only operations.
module alu_bitops
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         half_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o
);

    localparam int H = W / 2;

    logic [W-1:0] lane_mask;
    logic [W-1:0] raw;
    logic         top_b;

    // Active-lane mask and the operand's top bit for the selected width.
    always_comb begin
        lane_mask = half_i ? {{(W-H){1'b0}}, {H{1'b1}}} : {W{1'b1}};
        top_b     = half_i ? b_i[H-1] : b_i[W-1];
    end

    // Raw result per operation before lane masking.
    always_comb begin
        raw = '0;
        unique case (op_i)
            OP_MOV:         raw = b_i;
            OP_AND, OP_BIT: raw = a_i & b_i;
            OP_XOR:         raw = a_i ^ b_i;
            OP_BIC:         raw = a_i & ~b_i;
            OP_BIS:         raw = a_i | b_i;
            OP_RRC: begin
                raw = (b_i & lane_mask) >> 1;
                if (half_i) raw[H-1] = cin_i;
                else        raw[W-1] = cin_i;
            end
            OP_RRA: begin
                raw = (b_i & lane_mask) >> 1;
                if (half_i) raw[H-1] = top_b;
                else        raw[W-1] = top_b;
            end
            OP_SWPB:        raw = {b_i[H-1:0], b_i[W-1:H]};
            OP_SXT:         raw = {{(W-H){b_i[H-1]}}, b_i[H-1:0]};
            default:        raw = '0;
        endcase
    end

    // Clear the unused upper lane in byte mode.
    always_comb res_o = raw & lane_mask;

endmodule

// File: rtl/alu_core.sv
// ALU top: decodes the opcode fields, runs the adder and bit datapath, forms
// C/Z/N/V and registers result, strobes and flags with one cycle of latency.
// Assumes operands are already fetched and the status word uses C=0, Z=1, N=2, V=8.
module alu_core
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         is_single,
    input  logic [3:0]   major_op,
    input  logic [2:0]   minor_op,
    input  logic         byte_mode,
    input  logic [W-1:0] src_val,
    input  logic [W-1:0] dst_val,
    input  logic [W-1:0] status_in,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         result_we,
    output logic         c_out,
    output logic         z_out,
    output logic         n_out,
    output logic         v_out,
    output logic         flags_we
);

    localparam int H = W / 2;

    ctrl_t        ctrl;
    logic         eff_half;
    logic         add_cin;
    logic [W-1:0] sum;
    logic         sum_cout;
    logic         sum_ovf;
    logic [W-1:0] bit_res;
    logic         is_arith;
    logic [W-1:0] res_n;
    logic         res_top;
    logic         src_top;
    logic         dst_top;
    logic         c_n, z_n, n_n, v_n;
    op_e          op_q;
    logic         half_q;

    alu_decode u_dec (
        .is_single (is_single),
        .major_op  (major_op),
        .minor_op  (minor_op),
        .ctrl      (ctrl)
    );

    // Effective width and carry-in source for the adder.
    always_comb begin
        eff_half = byte_mode & ~ctrl.word_only;
        unique case (ctrl.cin)
            CIN_ONE:  add_cin = 1'b1;
            CIN_FLAG: add_cin = status_in[SR_C_BIT];
            default:  add_cin = 1'b0;
        endcase
    end

    alu_addsub #(.W(W)) u_add (
        .a_i    (dst_val),
        .b_i    (src_val),
        .inv_i  (ctrl.inv),
        .cin_i  (add_cin),
        .half_i (eff_half),
        .sum_o  (sum),
        .cout_o (sum_cout),
        .ovf_o  (sum_ovf)
    );

    alu_bitops #(.W(W)) u_bit (
        .op_i   (ctrl.op),
        .a_i    (dst_val),
        .b_i    (src_val),
        .half_i (eff_half),
        .cin_i  (status_in[SR_C_BIT]),
        .res_o  (bit_res)
    );

    // Select the datapath result and its sign bits at the active width.
    always_comb begin
        is_arith = ctrl.op inside {OP_ADD, OP_ADDC, OP_SUBC, OP_SUB, OP_CMP};
        res_n    = is_arith ? sum : bit_res;
        res_top  = eff_half ? res_n[H-1]   : res_n[W-1];
        src_top  = eff_half ? src_val[H-1] : src_val[W-1];
        dst_top  = eff_half ? dst_val[H-1] : dst_val[W-1];
    end

    // Next flag values per operation class; pass the incoming flags when not updated.
    always_comb begin
        c_n = status_in[SR_C_BIT];
        z_n = status_in[SR_Z_BIT];
        n_n = status_in[SR_N_BIT];
        v_n = status_in[SR_V_BIT];
        if (ctrl.fl) begin
            z_n = (res_n == '0);
            n_n = res_top;
            unique case (ctrl.op)
                OP_ADD, OP_ADDC, OP_SUBC, OP_SUB, OP_CMP: begin
                    c_n = sum_cout;
                    v_n = sum_ovf;
                end
                OP_XOR: begin
                    c_n = (res_n != '0);
                    v_n = src_top & dst_top;
                end
                OP_RRC, OP_RRA: begin
                    c_n = src_val[0];
                    v_n = 1'b0;
                end
                default: begin
                    c_n = (res_n != '0);
                    v_n = 1'b0;
                end
            endcase
        end
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result_we <= 1'b0;
            flags_we  <= 1'b0;
            result    <= '0;
            c_out     <= 1'b0;
            z_out     <= 1'b0;
            n_out     <= 1'b0;
            v_out     <= 1'b0;
            op_q      <= OP_NONE;
            half_q    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            result_we <= in_valid & ctrl.wr;
            flags_we  <= in_valid & ctrl.fl;
            if (in_valid) begin
                result <= res_n;
                c_out  <= c_n;
                z_out  <= z_n;
                n_out  <= n_n;
                v_out  <= v_n;
                op_q   <= ctrl.op;
                half_q <= eff_half;
            end
        end
    end

    // Strobes stay low when no operation was accepted.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!result_we && !flags_we));

    // An accepted operation is reported on the next edge.
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // Compare updates flags and never writes.
    assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q == OP_CMP) |-> (!result_we && flags_we));

    // Z agrees with a written result whenever flags are updated.
    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_we && result_we) |-> (z_out == (result == '0)));

    // Byte results keep the upper byte clear.
    assert_byte_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result_we && half_q) |-> (result[W-1:H] == '0));

    // Logic group: carry is the inverse of zero.
    assert_logic_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_we && op_q inside {OP_BIT, OP_AND, OP_XOR}) |-> (c_out == !z_out));

    // Right shifts clear overflow.
    assert_shift_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q inside {OP_RRC, OP_RRA}) |-> !v_out);

    // Without a flag update the incoming flags pass through.
    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !flags_we) |->
            (c_out == $past(status_in[SR_C_BIT]) && z_out == $past(status_in[SR_Z_BIT]) &&
             n_out == $past(status_in[SR_N_BIT]) && v_out == $past(status_in[SR_V_BIT])));

endmodule

// File: tb/tb_alu_core.sv
// Scoreboard bench: the driver pushes model expectations each cycle, the monitor pops and compares.
module tb_alu_core;

    typedef struct packed {
        logic        v;
        logic        we;
        logic        fw;
        logic [15:0] r;
        logic        c, z, n, vf;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        is_single = 1'b0;
    logic [3:0]  major_op = '0;
    logic [2:0]  minor_op = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] src_val = '0;
    logic [15:0] dst_val = '0;
    logic [15:0] status_in = '0;
    logic        out_valid, result_we, flags_we, c_out, z_out, n_out, v_out;
    logic [15:0] result;

    int   total = 0;
    int   bad = 0;
    bit   running = 1'b0;
    exp_t exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    alu_core dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_single(is_single),
        .major_op(major_op), .minor_op(minor_op), .byte_mode(byte_mode),
        .src_val(src_val), .dst_val(dst_val), .status_in(status_in),
        .out_valid(out_valid), .result(result), .result_we(result_we),
        .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out), .flags_we(flags_we)
    );

    // Independent model of each operation, written from the requirements.
    function automatic exp_t model(logic sgl, logic [3:0] maj, logic [2:0] mnr, logic byt,
                                   logic [15:0] s, logic [15:0] d, logic [15:0] sr);
        exp_t e;
        int unsigned mask, tb, a, b, bb, sum, res, cc, vv, cin;
        logic wr, fl;
        e = '0;
        e.v = 1'b1;
        e.c = sr[0]; e.z = sr[1]; e.n = sr[2]; e.vf = sr[8];
        mask = byt ? 32'hFF : 32'hFFFF;
        tb = byt ? 7 : 15;
        a = d & mask; b = s & mask; cin = sr[0];
        res = 0; cc = 0; vv = 0; wr = 0; fl = 0;
        if (!sgl) begin
            case (maj)
                4'd4: begin res = b; wr = 1; end
                4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin
                    bb  = (maj >= 7) ? (~b & mask) : b;
                    sum = a + bb + ((maj == 5) ? 0 : (maj == 6 || maj == 7) ? cin : 1);
                    res = sum & mask;
                    cc  = (sum >> (tb + 1)) & 1;
                    vv  = (((a >> tb) & 1) == ((bb >> tb) & 1)) && (((res >> tb) & 1) != ((a >> tb) & 1));
                    wr  = (maj != 9); fl = 1;
                end
                4'd11, 4'd14, 4'd15: begin
                    res = (maj == 14) ? (a ^ b) : (a & b);
                    cc  = (res != 0);
                    vv  = (maj == 14) ? ((a >> tb) & (b >> tb) & 1) : 0;
                    wr  = (maj != 11); fl = 1;
                end
                4'd12: begin res = a & ~b & mask; wr = 1; end
                4'd13: begin res = a | b; wr = 1; end
                default: ;
            endcase
        end else begin
            case (mnr)
                3'd0: begin res = (cin << tb) | (b >> 1); cc = b & 1; wr = 1; fl = 1; end
                3'd1: begin res = ((s & 255) << 8) | (s >> 8); wr = 1; end
                3'd2: begin res = (b >> 1) | (b & (1 << tb)); cc = b & 1; wr = 1; fl = 1; end
                3'd3: begin
                    res = s[7] ? ((s & 255) | 32'hFF00) : (s & 255);
                    tb = 15; cc = (res != 0); wr = 1; fl = 1;
                end
                default: ;
            endcase
        end
        if (fl) begin
            e.z = (res == 0);
            e.n = (res >> tb) & 1;
            e.c = cc[0];
            e.vf = vv[0];
        end
        e.r = res[15:0];
        e.we = wr;
        e.fw = fl;
        return e;
    endfunction

    task automatic drive(input logic sgl, input logic [3:0] maj, input logic [2:0] mnr, input logic byt,
                         input logic [15:0] s, input logic [15:0] d, input logic [15:0] sr, input string tag);
        @(negedge clk);
        in_valid = 1'b1; is_single = sgl; major_op = maj; minor_op = mnr;
        byte_mode = byt; src_val = s; dst_val = d; status_in = sr;
        exp_q.push_back(model(sgl, maj, mnr, byt, s, d, sr));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0; src_val = 16'hDEAD; dst_val = 16'hBEEF; status_in = 16'h0107;
        exp_q.push_back('0);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the outputs against the oldest expectation each cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (running && exp_q.size() > 1) begin
                exp_t e;
                string t;
                logic ok;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e.v)
                    ok = out_valid && result_we == e.we && flags_we == e.fw &&
                         (!e.we || result == e.r) &&
                         {c_out, z_out, n_out, v_out} == {e.c, e.z, e.n, e.vf};
                else
                    ok = !out_valid && !result_we && !flags_we;
                total++;
                if (!ok) begin
                    bad++;
                    $display("FAIL %s: got v=%b we=%b fw=%b r=%h czn v=%b%b%b%b, exp v=%b we=%b fw=%b r=%h czn v=%b%b%b%b",
                             t, out_valid, result_we, flags_we, result, c_out, z_out, n_out, v_out,
                             e.v, e.we, e.fw, e.r, e.c, e.z, e.n, e.vf);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        in_valid = 1'b1; src_val = 16'hFFFF; dst_val = 16'hFFFF; status_in = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (out_valid || result_we || flags_we || result != 16'h0 || {c_out, z_out, n_out, v_out} != 4'b0) begin
            bad++;
            $display("FAIL R1: got v=%b we=%b fw=%b r=%h flags=%b%b%b%b, exp all zero",
                     out_valid, result_we, flags_we, result, c_out, z_out, n_out, v_out);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        running = 1'b1;
        idle("R2 idle after reset");
        // R3 add / add with carry
        drive(0, 4'd5, 0, 0, 16'h0001, 16'h1234, 16'h0000, "R3 add");
        drive(0, 4'd5, 0, 0, 16'h0001, 16'hFFFF, 16'h0000, "R3 add carry-out zero");
        drive(0, 4'd6, 0, 0, 16'h0010, 16'h0020, 16'h0001, "R3 addc with carry");
        // R5 overflow
        drive(0, 4'd5, 0, 0, 16'h0001, 16'h7FFF, 16'h0000, "R5 add overflow");
        drive(0, 4'd8, 0, 0, 16'h0001, 16'h8000, 16'h0000, "R5 sub overflow");
        // R4 subtract / compare
        drive(0, 4'd8, 0, 0, 16'h1234, 16'h1234, 16'h0000, "R4 sub equal");
        drive(0, 4'd8, 0, 0, 16'h0005, 16'h0003, 16'h0001, "R4 sub borrow");
        drive(0, 4'd7, 0, 0, 16'h0003, 16'h0005, 16'h0000, "R4 subc no carry");
        drive(0, 4'd9, 0, 0, 16'h0042, 16'h0042, 16'h0000, "R4 cmp no write");
        // R6 no-flag writers
        drive(0, 4'd4, 0, 0, 16'hA5A5, 16'h0000, 16'h0105, "R6 mov");
        drive(0, 4'd12, 0, 0, 16'h00F0, 16'h0FFF, 16'h0002, "R6 bic");
        drive(0, 4'd13, 0, 0, 16'hF000, 16'h000F, 16'h0104, "R6 bis");
        // R7 logic group
        drive(0, 4'd11, 0, 0, 16'h0F00, 16'h00F0, 16'h0000, "R7 bit zero");
        drive(0, 4'd15, 0, 0, 16'h8F00, 16'h8001, 16'h0000, "R7 and negative");
        drive(0, 4'd14, 0, 0, 16'h8001, 16'h8001, 16'h0000, "R7 xor both negative");
        drive(0, 4'd14, 0, 0, 16'h00FF, 16'h0F0F, 16'h0100, "R7 xor");
        // R8 byte mode
        drive(0, 4'd5, 0, 1, 16'h1280, 16'h3480, 16'h0000, "R8 byte add");
        drive(0, 4'd8, 0, 1, 16'hFF01, 16'h0080, 16'h0000, "R8 byte sub");
        drive(0, 4'd4, 0, 1, 16'hABCD, 16'h1111, 16'h0000, "R8 byte mov");
        drive(0, 4'd14, 0, 1, 16'h0080, 16'hFF80, 16'h0000, "R8 byte xor");
        // R9 shifts
        drive(1, 4'd1, 3'd0, 0, 16'h0003, 16'h0000, 16'h0001, "R9 rrc carry in");
        drive(1, 4'd1, 3'd0, 0, 16'h0001, 16'h0000, 16'h0100, "R9 rrc to zero");
        drive(1, 4'd1, 3'd2, 0, 16'h8002, 16'h0000, 16'h0101, "R9 rra negative");
        drive(1, 4'd1, 3'd0, 1, 16'hFF02, 16'h0000, 16'h0001, "R9 byte rrc");
        drive(1, 4'd1, 3'd2, 1, 16'h1281, 16'h0000, 16'h0000, "R9 byte rra");
        // R10 swap / sign extend
        drive(1, 4'd1, 3'd1, 0, 16'h12AB, 16'h0000, 16'h0007, "R10 swpb");
        drive(1, 4'd1, 3'd1, 1, 16'h12AB, 16'h0000, 16'h0000, "R10 swpb byte select");
        drive(1, 4'd1, 3'd3, 0, 16'h1280, 16'h0000, 16'h0000, "R10 sxt negative");
        drive(1, 4'd1, 3'd3, 0, 16'hFF00, 16'h0000, 16'h0001, "R10 sxt zero");
        // R11 no-ops
        drive(0, 4'd10, 0, 0, 16'h1111, 16'h2222, 16'h0103, "R11 dadd");
        drive(0, 4'd2, 0, 0, 16'h1111, 16'h2222, 16'h0004, "R11 major 2");
        drive(1, 4'd1, 3'd5, 0, 16'h1111, 16'h2222, 16'h0001, "R11 minor 5");
        idle("R2 idle between");
        drive(0, 4'd5, 0, 0, 16'h8000, 16'h8000, 16'h0000, "R5 add negative overflow");
        idle("R2 idle tail");
        idle("R2 idle tail");
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule